// File: doc/BRIEF.md
# Dual-Bank Memory Access Arbiter

This block sits between a processor core and two on-chip memory banks. Each bank is a single-port word store, and either bank may hold instruction words and data words side by side; no bank is tied to a program or data role. Two buses issue requests: a program bus and a data bus. The program bus carries instruction fetches and data from the second address generator. The data bus carries data from the first address generator. The bank an access goes to is picked by the top address bit. The remaining bits pick a word inside that bank.

When the two live requests of one instruction go to different banks, both are served in the same cycle. When they go to the same bank, the data-bus access is served first. The program-bus access is copied into a holding register and served in one extra cycle. A stall output is high for the conflict cycle so the core repeats the instruction once. A fetch that the instruction cache already covers is dropped from arbitration. Read data comes back one cycle after the grant.

Top module: `dual_bank_arbiter`

## Requirements
- R1: After reset, `stall`, `pmRvalid` and `dmRvalid` are low while no request is presented.
- R2: When the live program-bus request and the data-bus request go to different banks (address bit ADDR_W-1 differs), `stall` stays low and both accesses are served in that cycle.
- R3: When the live program-bus request and the data-bus request go to the same bank, `stall` is high in that cycle.
- R4: On a conflict the data-bus access is served in the conflict cycle and the program-bus access in the next cycle. A data read's `dmRvalid` rises one cycle after the conflict and a program read's `pmRvalid` two cycles after it. On a conflict where both write the same word, the program-bus value is the one kept.
- R5: In the extra cycle after a conflict, both buses' inputs are ignored: no new read or write is performed and the held program access is used instead.
- R6: A program-bus request with `pmFetch`=1 and `cacheHit`=1 is not performed. It causes no stall and no `pmRvalid`.
- R7: `cacheHit` has no effect on a program-bus request with `pmFetch`=0 (a data access).
- R8: Address bit ADDR_W-1 selects bank 0 or 1, and bits ADDR_W-2..0 select the word. A word written through either bus reads back through either bus.
- R9: A read grant gives the valid strobe of its bus, high for exactly one cycle, one cycle after the grant, with the addressed word on the matching data port. A write grant gives no valid strobe.
- R10: `stall` is never high in two consecutive cycles.
- R11: All DATA_W bits of a word are stored and returned, so a full-width instruction word and a narrower data word in the low bits share a bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pmReq | input | 1 | Program-bus request |
| pmFetch | input | 1 | Program-bus request is an instruction fetch |
| cacheHit | input | 1 | Instruction cache covers this cycle's fetch |
| pmWe | input | 1 | Program-bus write |
| pmAddr | input | ADDR_W | Program-bus address (top bit = bank) |
| pmWdata | input | DATA_W | Program-bus write data |
| dmReq | input | 1 | Data-bus request |
| dmWe | input | 1 | Data-bus write |
| dmAddr | input | ADDR_W | Data-bus address (top bit = bank) |
| dmWdata | input | DATA_W | Data-bus write data |
| stall | output | 1 | Core must repeat the instruction for one extra cycle |
| pmRdata | output | DATA_W | Program-bus read data |
| pmRvalid | output | 1 | Program-bus read data valid |
| dmRdata | output | DATA_W | Data-bus read data |
| dmRvalid | output | 1 | Data-bus read data valid |

## Verification
The properties assume the core behaves as a stalled core should. It re-presents the same instruction in the cycle after `stall`. It treats inputs in that cycle as don't-care, and it asserts `pmFetch` only on program-bus reads. The bench drives junk requests in every extra cycle, including writes to other words, to show they are ignored. It then reads every word back to catch any stray write. Its sweep covers every pairing of program-bus kind (none, cached fetch, fetch, data read, data write) with data-bus kind (none, read, write), over all bank pairs, with both equal and different word indices.

// File: rtl/dbarb_pkg.sv
package dbarb_pkg;
  localparam int NUM_BANKS = 2;

  typedef struct packed {
    logic [NUM_BANKS-1:0] bankEn;
    logic [NUM_BANKS-1:0] bankWe;
    logic [NUM_BANKS-1:0] bankFromPm;
    logic                 capturePm;
    logic                 useHeldPm;
    logic                 pmRead;
    logic                 dmRead;
  } arbStrobes_t;
endpackage

// File: rtl/dbarb_bank.sv
module dbarb_bank #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end
endmodule

// File: rtl/dbarb_ctrl.sv
module dbarb_ctrl
  import dbarb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pmReq,
  input  logic        pmFetch,
  input  logic        cacheHit,
  input  logic        pmWe,
  input  logic        pmBank,
  input  logic        dmReq,
  input  logic        dmWe,
  input  logic        dmBank,
  output logic        stall,
  output arbStrobes_t strobes
);
  logic pendPm, pendBank, pendWe;
  logic pmLive, clash;

  assign pmLive = pmReq && !(pmFetch && cacheHit);
  assign clash  = !pendPm && pmLive && dmReq && (pmBank == dmBank);
  assign stall  = clash;

  always_comb begin
    strobes = '0;
    if (pendPm) begin
      strobes.bankEn[pendBank]     = 1'b1;
      strobes.bankWe[pendBank]     = pendWe;
      strobes.bankFromPm[pendBank] = 1'b1;
      strobes.useHeldPm            = 1'b1;
      strobes.pmRead               = !pendWe;
    end else begin
      if (dmReq) begin
        strobes.bankEn[dmBank] = 1'b1;
        strobes.bankWe[dmBank] = dmWe;
        strobes.dmRead         = !dmWe;
      end
      if (pmLive && !clash) begin
        strobes.bankEn[pmBank]     = 1'b1;
        strobes.bankWe[pmBank]     = pmWe;
        strobes.bankFromPm[pmBank] = 1'b1;
        strobes.pmRead             = !pmWe;
      end
      strobes.capturePm = clash;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPm   <= 1'b0;
      pendBank <= 1'b0;
      pendWe   <= 1'b0;
    end else begin
      pendPm <= clash;
      if (clash) begin
        pendBank <= pmBank;
        pendWe   <= pmWe;
      end
    end
  end
endmodule

// File: rtl/dbarb_dpath.sv
module dbarb_dpath
  import dbarb_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobes_t       strobes,
  input  logic [ADDR_W-1:0] pmAddr,
  input  logic [DATA_W-1:0] pmWdata,
  input  logic [ADDR_W-1:0] dmAddr,
  input  logic [DATA_W-1:0] dmWdata,
  output logic [DATA_W-1:0] pmRdata,
  output logic              pmRvalid,
  output logic [DATA_W-1:0] dmRdata,
  output logic              dmRvalid
);
  localparam int IDX_W = ADDR_W - 1;

  logic [ADDR_W-1:0] heldAddr, pmAddrSel;
  logic [DATA_W-1:0] heldData, pmDataSel;
  logic [DATA_W-1:0] bankQ [NUM_BANKS];
  logic              pmSrcQ, dmSrcQ;

  always_ff @(posedge clk) begin
    if (strobes.capturePm) begin
      heldAddr <= pmAddr;
      heldData <= pmWdata;
    end
  end

  assign pmAddrSel = strobes.useHeldPm ? heldAddr : pmAddr;
  assign pmDataSel = strobes.useHeldPm ? heldData : pmWdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [IDX_W-1:0]  idxSel;
    logic [DATA_W-1:0] wdSel;
    assign idxSel = strobes.bankFromPm[b] ? pmAddrSel[IDX_W-1:0] : dmAddr[IDX_W-1:0];
    assign wdSel  = strobes.bankFromPm[b] ? pmDataSel : dmWdata;
    dbarb_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .en    (strobes.bankEn[b]),
      .we    (strobes.bankWe[b]),
      .idx   (idxSel),
      .wdata (wdSel),
      .rdata (bankQ[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pmRvalid <= 1'b0;
      dmRvalid <= 1'b0;
      pmSrcQ   <= 1'b0;
      dmSrcQ   <= 1'b0;
    end else begin
      pmRvalid <= strobes.pmRead;
      dmRvalid <= strobes.dmRead;
      if (strobes.pmRead) pmSrcQ <= pmAddrSel[ADDR_W-1];
      if (strobes.dmRead) dmSrcQ <= dmAddr[ADDR_W-1];
    end
  end

  assign pmRdata = bankQ[pmSrcQ];
  assign dmRdata = bankQ[dmSrcQ];
endmodule

// File: rtl/dual_bank_arbiter.sv
module dual_bank_arbiter
  import dbarb_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pmReq,
  input  logic              pmFetch,
  input  logic              cacheHit,
  input  logic              pmWe,
  input  logic [ADDR_W-1:0] pmAddr,
  input  logic [DATA_W-1:0] pmWdata,
  input  logic              dmReq,
  input  logic              dmWe,
  input  logic [ADDR_W-1:0] dmAddr,
  input  logic [DATA_W-1:0] dmWdata,
  output logic              stall,
  output logic [DATA_W-1:0] pmRdata,
  output logic              pmRvalid,
  output logic [DATA_W-1:0] dmRdata,
  output logic              dmRvalid
);
  arbStrobes_t strobes;

  dbarb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pmReq    (pmReq),
    .pmFetch  (pmFetch),
    .cacheHit (cacheHit),
    .pmWe     (pmWe),
    .pmBank   (pmAddr[ADDR_W-1]),
    .dmReq    (dmReq),
    .dmWe     (dmWe),
    .dmBank   (dmAddr[ADDR_W-1]),
    .stall    (stall),
    .strobes  (strobes)
  );

  dbarb_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pmAddr   (pmAddr),
    .pmWdata  (pmWdata),
    .dmAddr   (dmAddr),
    .dmWdata  (dmWdata),
    .pmRdata  (pmRdata),
    .pmRvalid (pmRvalid),
    .dmRdata  (dmRdata),
    .dmRvalid (dmRvalid)
  );
endmodule

// File: rtl/dbarb_chk.sv
module dbarb_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              pmReq,
  input logic              pmFetch,
  input logic              cacheHit,
  input logic              pmWe,
  input logic [ADDR_W-1:0] pmAddr,
  input logic              dmReq,
  input logic              dmWe,
  input logic [ADDR_W-1:0] dmAddr,
  input logic              stall,
  input logic              pmRvalid,
  input logic              dmRvalid
);
  logic prevStall;
  logic sameBank;

  assign sameBank = pmAddr[ADDR_W-1] == dmAddr[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevStall <= 1'b0;
    else       prevStall <= stall;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!pmReq && !dmReq && !prevStall) |-> !stall);

  p_split_no_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!prevStall && dmReq && pmReq && !(pmFetch && cacheHit) && !sameBank) |-> !stall);

  p_clash_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!prevStall && dmReq && pmReq && !(pmFetch && cacheHit) && sameBank) |-> stall);

  p_pm_deferred_r4: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !pmRvalid);

  p_pm_late_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !pmWe) |=> ##1 pmRvalid);

  p_dm_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !dmWe) |=> dmRvalid);

  p_extra_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    prevStall |=> !dmRvalid);

  p_cached_fetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!prevStall && pmReq && pmFetch && cacheHit) |=> !pmRvalid);

  p_cached_no_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!prevStall && pmReq && pmFetch && cacheHit) |-> !stall);

  p_data_hit_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!prevStall && pmReq && !pmFetch && cacheHit && dmReq && sameBank) |-> stall);

  p_write_no_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!prevStall && dmReq && dmWe) |=> !dmRvalid);

  p_stall_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);
endmodule

bind dual_bank_arbiter dbarb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pmReq    (pmReq),
  .pmFetch  (pmFetch),
  .cacheHit (cacheHit),
  .pmWe     (pmWe),
  .pmAddr   (pmAddr),
  .dmReq    (dmReq),
  .dmWe     (dmWe),
  .dmAddr   (dmAddr),
  .stall    (stall),
  .pmRvalid (pmRvalid),
  .dmRvalid (dmRvalid)
);

// File: tb/dual_bank_arbiter_tb.sv
module dual_bank_arbiter_tb;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 48;
  localparam int IDX_N  = 1 << (ADDR_W - 1);

  logic              clk = 1'b0;
  logic              rstN;
  logic              pmReq, pmFetch, cacheHit, pmWe, dmReq, dmWe;
  logic [ADDR_W-1:0] pmAddr, dmAddr;
  logic [DATA_W-1:0] pmWdata, dmWdata, pmRdata, dmRdata;
  logic              stall, pmRvalid, dmRvalid;

  int nTests = 0;
  int nFail  = 0;
  logic [31:0] seq = 32'h100;
  logic [DATA_W-1:0] model [2][IDX_N];

  always #10 clk = ~clk;

  dual_bank_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .pmReq(pmReq), .pmFetch(pmFetch), .cacheHit(cacheHit), .pmWe(pmWe),
    .pmAddr(pmAddr), .pmWdata(pmWdata),
    .dmReq(dmReq), .dmWe(dmWe), .dmAddr(dmAddr), .dmWdata(dmWdata),
    .stall(stall), .pmRdata(pmRdata), .pmRvalid(pmRvalid),
    .dmRdata(dmRdata), .dmRvalid(dmRvalid)
  );

  task automatic check(input bit ok, input string req,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mkWord(input logic [31:0] s);
    return {s[15:0] ^ 16'hC3C3, ~s[15:0], s[15:0]};
  endfunction

  task automatic setIdle();
    pmReq = 0; pmFetch = 0; cacheHit = 0; pmWe = 0;
    dmReq = 0; dmWe = 0;
  endtask

  // pk: 0 none, 1 cached fetch, 2 fetch, 3 data read (cacheHit=1), 4 data write
  // dk: 0 none, 1 read, 2 write
  task automatic runOp(input int pk, input logic [ADDR_W-1:0] pa,
                       input int dk, input logic [ADDR_W-1:0] da);
    bit pmLive, clash, pmRd, dmRd;
    logic [DATA_W-1:0] expDm, expPm;
    int pb, pi, db, di;
    pb = int'(pa[ADDR_W-1]); pi = int'(pa[ADDR_W-2:0]);
    db = int'(da[ADDR_W-1]); di = int'(da[ADDR_W-2:0]);
    expDm = '0; expPm = '0;
    @(negedge clk);
    pmReq = (pk != 0); pmFetch = (pk == 1 || pk == 2);
    cacheHit = (pk == 1 || pk == 3); pmWe = (pk == 4);
    pmAddr = pa; seq++; pmWdata = mkWord(seq);
    dmReq = (dk != 0); dmWe = (dk == 2);
    dmAddr = da; seq++; dmWdata = mkWord(seq);
    #1;
    pmLive = (pk >= 2);
    pmRd = (pk == 2 || pk == 3);
    dmRd = (dk == 1);
    clash = pmLive && (dk != 0) && (pb == db);
    // R2 / R3 / R6 / R7: stall only on a same-bank pair of live requests
    check(stall == clash, clash ? "R3 stall on clash" :
          (pk == 1 ? "R6 cached fetch no stall" : (pk == 3 ? "R7 hit ignored on data" : "R2 no stall")),
          {47'b0, stall}, {47'b0, clash});
    if (dmRd) expDm = model[db][di];
    if (dk == 2) model[db][di] = dmWdata;
    if (!clash) begin
      if (pmRd) expPm = model[pb][pi];
      if (pk == 4) model[pb][pi] = pmWdata;
    end
    @(negedge clk);
    check(dmRvalid == dmRd, "R9 dm valid timing", {47'b0, dmRvalid}, {47'b0, dmRd});
    if (dmRd) check(dmRdata == expDm, "R8 dm read data", dmRdata, expDm);
    if (!clash) begin
      check(pmRvalid == pmRd, pk == 1 ? "R6 no pm valid on cached fetch" : "R9 pm valid timing",
            {47'b0, pmRvalid}, {47'b0, pmRd});
      if (pmRd) check(pmRdata == expPm, "R11 pm read data", pmRdata, expPm);
      setIdle();
    end else begin
      check(pmRvalid == 1'b0, "R4 pm deferred", {47'b0, pmRvalid}, 48'h0);
      // R5: junk in the extra cycle, must be ignored
      pmReq = 1; pmFetch = 0; cacheHit = 0; pmWe = 1; pmAddr = pa ^ 5'h03;
      pmWdata = 48'hBAD0_BAD0_BAD0;
      dmReq = 1; dmWe = 1; dmAddr = da ^ 5'h06; dmWdata = 48'hBAD1_BAD1_BAD1;
      #1;
      check(stall == 1'b0, "R10 single stall", {47'b0, stall}, 48'h0);
      if (pmRd) expPm = model[pb][pi];
      if (pk == 4) model[pb][pi] = mkWord(seq - 1);
      @(negedge clk);
      check(pmRvalid == pmRd, "R4 pm served second", {47'b0, pmRvalid}, {47'b0, pmRd});
      if (pmRd) check(pmRdata == expPm, "R4 pm data after dm", pmRdata, expPm);
      check(dmRvalid == 1'b0, "R5 dm junk ignored", {47'b0, dmRvalid}, 48'h0);
      setIdle();
    end
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    setIdle();
    pmAddr = '0; dmAddr = '0; pmWdata = '0; dmWdata = '0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    check(stall == 0 && pmRvalid == 0 && dmRvalid == 0, "R1 reset quiet",
          {45'b0, stall, pmRvalid, dmRvalid}, 48'h0);

    // R8 / R2: fill both banks, paired across banks
    for (int i = 0; i < IDX_N; i++) begin
      runOp(4, {1'b0, 4'(i)}, 2, {1'b1, 4'(i)});
    end

    // Sweep all pairings, banks and index relations (R2..R7, R9, R11)
    for (int pk = 0; pk < 5; pk++)
      for (int dk = 0; dk < 3; dk++)
        for (int pb = 0; pb < 2; pb++)
          for (int db = 0; db < 2; db++)
            for (int s = 0; s < 2; s++) begin
              int n, pidx, didx;
              n = pk * 24 + dk * 8 + pb * 4 + db * 2 + s;
              pidx = (n * 3) % IDX_N;
              didx = s ? pidx : (n * 7 + 2) % IDX_N;
              runOp(pk, {1'(pb), 4'(pidx)}, dk, {1'(db), 4'(didx)});
            end

    // R5 / R8: read back every word, both buses, to catch stray writes
    for (int i = 0; i < IDX_N; i++) begin
      runOp(3, {1'b0, 4'(i)}, 1, {1'b1, 4'(i)});
      runOp(2, {1'b1, 4'(i)}, 1, {1'b0, 4'(i)});
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule